// File: doc/BRIEF.md
# Boundary-Scan Instruction Register and Data-Register Select

This block holds the current test instruction of a four-bit boundary-scan port and decides which data register sits in the serial path between the test data input and the test data output. A shift stage collects the new instruction bit by bit while the previous one stays in force in a separate hold stage. The hold stage changes only when the update strobe arrives, so the data-register selection never moves in the middle of a data scan.

The block is driven by an external TAP state machine through one-cycle state strobes sampled on the rising test clock. The held code is decoded into a one-hot select across six data registers. Two of these, the single-bit bypass stage and the 32-bit identification register, are built here. The boundary chain and the three debug-access registers live outside and are seen only through their serial outputs. Two mode flags tell the boundary cells whether the preloaded values drive the pads or the core. The output bit is registered on the falling test clock.

Top module: `tap_instr_unit`

## Requirements
- R1: Driving `trst_n` low asynchronously sets the held instruction to 1110 (identification) and `tdo` to 0. A rising `tck` with `st_tlr` high does the same to the held instruction, and it wins over `st_upd_ir` in the same cycle.
- R2: A rising `tck` with `st_cap_ir` high loads 0001 into the shift stage. Each rising `tck` with `st_shift_ir` high moves the stage one place toward bit 0 and takes `tdi` into bit 3. Bit 0 is the one presented on `tdo`.
- R3: A rising `tck` with `st_upd_ir` high (and `st_tlr` low) copies the shift stage into `ir_q`. Without that strobe or `st_tlr`, `ir_q` keeps its value, including during IR shifting.
- R4: `dr_sel` is one-hot with bit 0 boundary chain, bit 1 abort, bit 2 debug-port access, bit 3 access-port access, bit 4 identification, bit 5 bypass. Codes 0000, 0001 and 0010 select bit 0; 1000 selects bit 1; 1010 selects bit 2; 1011 selects bit 3; 1110 selects bit 4; 1111 selects bit 5.
- R5: Every code other than those eight selects bypass (`dr_sel` = 100000) and raises neither mode flag.
- R6: `pad_drive` is 1 exactly when `ir_q` is 0000, and `core_drive` is 1 exactly when `ir_q` is 0001. Under 0010 both are 0.
- R7: With bypass selected, capture-DR loads 0 into the bypass stage and shift-DR takes `tdi`, so `tdo` repeats `tdi` one clock later, preceded by a 0.
- R8: With identification selected, capture-DR loads `ID_VALUE`, and shift-DR sends it out on `tdo` LSB first while `tdi` fills in from the top.
- R9: With an external register selected (boundary, abort, debug-port, access-port), `tdo` during shift-DR carries that register's serial input as sampled at the falling `tck`.
- R10: `tdo` is registered on the falling `tck`. It takes the IR shift LSB while `st_shift_ir` is high, the selected data register's output while `st_shift_dr` is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| st_tlr | input | 1 | TAP is in test-logic-reset |
| st_cap_ir | input | 1 | TAP is in capture-IR |
| st_shift_ir | input | 1 | TAP is in shift-IR |
| st_upd_ir | input | 1 | TAP is in update-IR |
| st_cap_dr | input | 1 | TAP is in capture-DR |
| st_shift_dr | input | 1 | TAP is in shift-DR |
| tdi | input | 1 | Serial test data in |
| bsr_so | input | 1 | Serial output of the boundary chain |
| abort_so | input | 1 | Serial output of the abort register |
| dpacc_so | input | 1 | Serial output of the debug-port access register |
| apacc_so | input | 1 | Serial output of the access-port access register |
| tdo | output | 1 | Serial test data out, changes on falling tck |
| dr_sel | output | 6 | One-hot data-register select |
| ir_q | output | 4 | Instruction in force |
| pad_drive | output | 1 | Boundary cells drive the pads from preloaded data |
| core_drive | output | 1 | Boundary cells drive the core from preloaded data |

## Verification
The test-logic-reset strobe and the instruction update can arrive on the same rising edge, and so can a pending shift-stage value and a running data scan. The bench provokes the first case by shifting 0000 (pad-drive mode) into the shift stage and then raising both `st_tlr` and `st_upd_ir` together. It judges the result by requiring the identification code in `ir_q` with both mode flags low on the next cycle. For the second case it shifts a new code without updating and then runs a data scan, requiring the old selection and its `tdo` stream to persist.

// File: rtl/tap_ir_pkg.sv
package tap_ir_pkg;

  localparam int IR_W = 4;
  localparam int DR_N = 6;

  // one-hot positions of the data-register select
  localparam int DR_BSR = 0;
  localparam int DR_ABT = 1;
  localparam int DR_DPA = 2;
  localparam int DR_APA = 3;
  localparam int DR_IDC = 4;
  localparam int DR_BYP = 5;

  typedef enum logic [IR_W-1:0] {
    OP_PADTEST  = 4'b0000,
    OP_CORETEST = 4'b0001,
    OP_SNAPSHOT = 4'b0010,
    OP_DBGABORT = 4'b1000,
    OP_DBGPORT  = 4'b1010,
    OP_ACCPORT  = 4'b1011,
    OP_IDENT    = 4'b1110,
    OP_PASS     = 4'b1111
  } instr_e;

  localparam logic [IR_W-1:0] IR_CAPTURE = 4'b0001;
  localparam logic [IR_W-1:0] IR_RESET   = OP_IDENT;

  typedef struct packed {
    logic [DR_N-1:0] sel;
    logic            pad_drive;
    logic            core_drive;
  } decode_t;

  function automatic decode_t decode_instr(input logic [IR_W-1:0] code);
    decode_t d;
    d.sel        = '0;
    d.pad_drive  = 1'b0;
    d.core_drive = 1'b0;
    case (code)
      OP_PADTEST:  begin d.sel[DR_BSR] = 1'b1; d.pad_drive  = 1'b1; end
      OP_CORETEST: begin d.sel[DR_BSR] = 1'b1; d.core_drive = 1'b1; end
      OP_SNAPSHOT: d.sel[DR_BSR] = 1'b1;
      OP_DBGABORT: d.sel[DR_ABT] = 1'b1;
      OP_DBGPORT:  d.sel[DR_DPA] = 1'b1;
      OP_ACCPORT:  d.sel[DR_APA] = 1'b1;
      OP_IDENT:    d.sel[DR_IDC] = 1'b1;
      default:     d.sel[DR_BYP] = 1'b1;  // unlisted codes and OP_PASS
    endcase
    return d;
  endfunction

  function automatic logic [IR_W-1:0] shift_toward_lsb(input logic [IR_W-1:0] cur,
                                                       input logic            din);
    return {din, cur[IR_W-1:1]};
  endfunction

endpackage

// File: rtl/tap_ir_stage.sv
module tap_ir_stage
  import tap_ir_pkg::*;
#(
  parameter int              W   = IR_W,
  parameter logic [W-1:0]    CAP = IR_CAPTURE,
  parameter logic [W-1:0]    RST = IR_RESET
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         tlr,
  input  logic         cap,
  input  logic         shift,
  input  logic         upd,
  input  logic         tdi,
  output logic [W-1:0] shift_q,
  output logic [W-1:0] hold_q,
  output logic         upd_ev
);

  logic [W-1:0] shift_d;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic serial_in;
    if (i == W-1) begin : g_top
      assign serial_in = tdi;
    end else begin : g_mid
      assign serial_in = shift_q[i+1];
    end
    assign shift_d[i] = cap ? CAP[i] : (shift ? serial_in : shift_q[i]);
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) shift_q <= CAP;
    else         shift_q <= shift_d;
  end

  // update event; test-logic-reset has priority
  assign upd_ev = upd & ~tlr;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)     hold_q <= RST;
    else if (tlr)    hold_q <= RST;
    else if (upd_ev) hold_q <= shift_q;
  end

endmodule

// File: rtl/tap_ir_decode.sv
module tap_ir_decode
  import tap_ir_pkg::*;
(
  input  logic [IR_W-1:0] hold_q,
  output logic [DR_N-1:0] sel,
  output logic            pad_drive,
  output logic            core_drive
);

  decode_t dec;

  always_comb dec = decode_instr(hold_q);

  assign sel        = dec.sel;
  assign pad_drive  = dec.pad_drive;
  assign core_drive = dec.core_drive;

endmodule

// File: rtl/tap_dr_local.sv
module tap_dr_local #(
  parameter int                ID_W     = 32,
  parameter logic [ID_W-1:0]   ID_VALUE = 32'h1A5C_3E2D
) (
  input  logic tck,
  input  logic trst_n,
  input  logic sel_byp,
  input  logic sel_id,
  input  logic cap_dr,
  input  logic shift_dr,
  input  logic tdi,
  output logic byp_so,
  output logic id_so
);

  logic            byp_q;
  logic [ID_W-1:0] id_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 byp_q <= 1'b0;
    else if (sel_byp && cap_dr)  byp_q <= 1'b0;
    else if (sel_byp && shift_dr) byp_q <= tdi;
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)                 id_q <= ID_VALUE;
    else if (sel_id && cap_dr)   id_q <= ID_VALUE;
    else if (sel_id && shift_dr) id_q <= {tdi, id_q[ID_W-1:1]};
  end

  assign byp_so = byp_q;
  assign id_so  = id_q[0];

endmodule

// File: rtl/tap_tdo_mux.sv
module tap_tdo_mux #(
  parameter int N = 6
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         shift_ir,
  input  logic         shift_dr,
  input  logic         ir_so,
  input  logic [N-1:0] sel,
  input  logic [N-1:0] so_vec,
  output logic         tdo
);

  logic [N-1:0] gated;
  logic         dr_so;
  logic         tdo_d;

  for (genvar i = 0; i < N; i++) begin : g_gate
    assign gated[i] = sel[i] & so_vec[i];
  end

  assign dr_so = |gated;
  assign tdo_d = shift_ir ? ir_so : (shift_dr ? dr_so : 1'b0);

  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) tdo <= 1'b0;
    else         tdo <= tdo_d;
  end

endmodule

// File: rtl/tap_instr_unit.sv
module tap_instr_unit
  import tap_ir_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h1A5C_3E2D
) (
  input  logic            tck,
  input  logic            trst_n,
  input  logic            st_tlr,
  input  logic            st_cap_ir,
  input  logic            st_shift_ir,
  input  logic            st_upd_ir,
  input  logic            st_cap_dr,
  input  logic            st_shift_dr,
  input  logic            tdi,
  input  logic            bsr_so,
  input  logic            abort_so,
  input  logic            dpacc_so,
  input  logic            apacc_so,
  output logic            tdo,
  output logic [DR_N-1:0] dr_sel,
  output logic [IR_W-1:0] ir_q,
  output logic            pad_drive,
  output logic            core_drive
);

  // named internal events for the checker
  logic [IR_W-1:0] ir_shift_q;
  logic            upd_ev;
  logic            byp_so;
  logic            id_so;
  logic [DR_N-1:0] so_vec;

  tap_ir_stage #(.W(IR_W), .CAP(IR_CAPTURE), .RST(IR_RESET)) u_stage (
    .tck     (tck),
    .trst_n  (trst_n),
    .tlr     (st_tlr),
    .cap     (st_cap_ir),
    .shift   (st_shift_ir),
    .upd     (st_upd_ir),
    .tdi     (tdi),
    .shift_q (ir_shift_q),
    .hold_q  (ir_q),
    .upd_ev  (upd_ev)
  );

  tap_ir_decode u_decode (
    .hold_q     (ir_q),
    .sel        (dr_sel),
    .pad_drive  (pad_drive),
    .core_drive (core_drive)
  );

  tap_dr_local #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) u_local (
    .tck      (tck),
    .trst_n   (trst_n),
    .sel_byp  (dr_sel[DR_BYP]),
    .sel_id   (dr_sel[DR_IDC]),
    .cap_dr   (st_cap_dr),
    .shift_dr (st_shift_dr),
    .tdi      (tdi),
    .byp_so   (byp_so),
    .id_so    (id_so)
  );

  assign so_vec[DR_BSR] = bsr_so;
  assign so_vec[DR_ABT] = abort_so;
  assign so_vec[DR_DPA] = dpacc_so;
  assign so_vec[DR_APA] = apacc_so;
  assign so_vec[DR_IDC] = id_so;
  assign so_vec[DR_BYP] = byp_so;

  tap_tdo_mux #(.N(DR_N)) u_tdo (
    .tck      (tck),
    .trst_n   (trst_n),
    .shift_ir (st_shift_ir),
    .shift_dr (st_shift_dr),
    .ir_so    (ir_shift_q[0]),
    .sel      (dr_sel),
    .so_vec   (so_vec),
    .tdo      (tdo)
  );

endmodule

// File: rtl/tap_instr_unit_chk.sv
module tap_instr_unit_chk
  import tap_ir_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            st_tlr,
  input logic            st_cap_ir,
  input logic            st_upd_ir,
  input logic            upd_ev,
  input logic [IR_W-1:0] ir_shift_q,
  input logic [IR_W-1:0] ir_q,
  input logic [DR_N-1:0] dr_sel,
  input logic            pad_drive,
  input logic            core_drive
);

  assert_reset_ident_R1: assert property (@(posedge tck) disable iff (!trst_n)
    st_tlr |=> (ir_q == IR_RESET));

  assert_capture_pattern_R2: assert property (@(posedge tck) disable iff (!trst_n)
    st_cap_ir |=> (ir_shift_q == IR_CAPTURE));

  assert_update_copy_R3: assert property (@(posedge tck) disable iff (!trst_n)
    upd_ev |=> (ir_q == $past(ir_shift_q)));

  assert_hold_stable_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (!st_upd_ir && !st_tlr) |=> $stable(ir_q));

  assert_select_onehot_R4: assert property (@(posedge tck) disable iff (!trst_n)
    $countones(dr_sel) == 1);

  assert_flags_exclusive_R6: assert property (@(posedge tck) disable iff (!trst_n)
    !(pad_drive && core_drive));

  assert_flags_need_chain_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (pad_drive || core_drive) |-> dr_sel[DR_BSR]);

endmodule

bind tap_instr_unit tap_instr_unit_chk u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .st_tlr     (st_tlr),
  .st_cap_ir  (st_cap_ir),
  .st_upd_ir  (st_upd_ir),
  .upd_ev     (upd_ev),
  .ir_shift_q (ir_shift_q),
  .ir_q       (ir_q),
  .dr_sel     (dr_sel),
  .pad_drive  (pad_drive),
  .core_drive (core_drive)
);

// File: tb/test_tap_instr_unit.sv
module test_tap_instr_unit;

  localparam int          CLK_P  = 10;
  localparam logic [31:0] ID_VAL = 32'h1A5C_3E2D;

  logic       tck = 1'b0;
  logic       trst_n = 1'b0;
  logic       st_tlr = 0, st_cap_ir = 0, st_shift_ir = 0, st_upd_ir = 0;
  logic       st_cap_dr = 0, st_shift_dr = 0, tdi = 0;
  logic       bsr_so = 0, abort_so = 0, dpacc_so = 0, apacc_so = 0;
  logic       tdo;
  logic [5:0] dr_sel;
  logic [3:0] ir_q;
  logic       pad_drive, core_drive;

  tap_instr_unit #(.ID_W(32), .ID_VALUE(ID_VAL)) i_tap_instr_unit (
    .tck(tck), .trst_n(trst_n), .st_tlr(st_tlr), .st_cap_ir(st_cap_ir),
    .st_shift_ir(st_shift_ir), .st_upd_ir(st_upd_ir), .st_cap_dr(st_cap_dr),
    .st_shift_dr(st_shift_dr), .tdi(tdi), .bsr_so(bsr_so), .abort_so(abort_so),
    .dpacc_so(dpacc_so), .apacc_so(apacc_so), .tdo(tdo), .dr_sel(dr_sel),
    .ir_q(ir_q), .pad_drive(pad_drive), .core_drive(core_drive)
  );

  always #(CLK_P/2) tck = ~tck;

  int    n_vec = 0;
  int    n_bad = 0;
  int    pat   = 0;
  string ir_tag = "R1";

  // behavioural reference state
  bit ir_sh[$];   // index 0 is the bit nearest tdo
  bit id_sh[$];
  int m_hold;
  bit m_byp;
  bit m_tdo;

  function automatic int exp_dr(int code);
    if (code == 0 || code == 1 || code == 2) return 0;
    if (code == 8)  return 1;
    if (code == 10) return 2;
    if (code == 11) return 3;
    if (code == 14) return 4;
    return 5;
  endfunction

  function automatic bit listed(int code);
    return code inside {0, 1, 2, 8, 10, 11, 14, 15};
  endfunction

  function automatic int pack_ir();
    int v = 0;
    foreach (ir_sh[i]) v += int'(ir_sh[i]) << i;
    return v;
  endfunction

  task automatic load_id();
    id_sh.delete();
    for (int i = 0; i < 32; i++) id_sh.push_back(ID_VAL[i]);
  endtask

  task automatic model_reset();
    ir_sh = '{1'b1, 1'b0, 1'b0, 1'b0};
    m_hold = 14;
    m_byp = 1'b0;
    m_tdo = 1'b0;
    load_id();
  endtask

  task automatic cmp(string tag, int act, int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // called 2 time units after a rising edge
  task automatic step(bit tlr, bit cir, bit sir, bit uir, bit cdr, bit sdr, bit din);
    int    sel;
    int    old_ir;
    string ttag;
    st_tlr = tlr; st_cap_ir = cir; st_shift_ir = sir; st_upd_ir = uir;
    st_cap_dr = cdr; st_shift_dr = sdr; tdi = din;
    pat++;
    bsr_so = pat[0]; abort_so = pat[1]; dpacc_so = pat[2] ^ pat[0]; apacc_so = pat[3];
    sel = exp_dr(m_hold);
    if (!trst_n)   m_tdo = 1'b0;
    else if (sir)  m_tdo = ir_sh[0];
    else if (sdr) begin
      case (sel)
        0: m_tdo = bsr_so;
        1: m_tdo = abort_so;
        2: m_tdo = dpacc_so;
        3: m_tdo = apacc_so;
        4: m_tdo = id_sh[0];
        default: m_tdo = m_byp;
      endcase
    end else m_tdo = 1'b0;
    if (sir)           ttag = "R2";
    else if (!sdr)     ttag = "R10";
    else if (sel == 5) ttag = "R7";
    else if (sel == 4) ttag = "R8";
    else               ttag = "R9";
    #(CLK_P/2);
    cmp(ir_tag, int'(ir_q), m_hold);
    cmp(listed(m_hold) ? "R4" : "R5", int'(dr_sel), 1 << sel);
    cmp("R6", int'({pad_drive, core_drive}), int'({m_hold == 0, m_hold == 1}));
    cmp(ttag, int'(tdo), int'(m_tdo));
    @(posedge tck);
    if (!trst_n) model_reset();
    else begin
      old_ir = pack_ir();
      if (cir) ir_sh = '{1'b1, 1'b0, 1'b0, 1'b0};
      else if (sir) begin void'(ir_sh.pop_front()); ir_sh.push_back(din); end
      if (tlr)      m_hold = 14;
      else if (uir) m_hold = old_ir;
      if (sel == 5) begin
        if (cdr) m_byp = 1'b0; else if (sdr) m_byp = din;
      end
      if (sel == 4) begin
        if (cdr) load_id();
        else if (sdr) begin void'(id_sh.pop_front()); id_sh.push_back(din); end
      end
    end
    #2;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic shift_ir_code(int code);
    step(0, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) step(0, 0, 1, 0, 0, 0, code[i]);
  endtask

  task automatic load_ir(int code);
    shift_ir_code(code);
    step(0, 0, 0, 1, 0, 0, 0);
  endtask

  task automatic dr_scan(int n, int seed);
    step(0, 0, 0, 0, 1, 0, 0);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 1, seed[i % 32]);
    idle();
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_vec++; n_bad++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    model_reset();
    @(posedge tck); #2;
    // R1: reset state while trst_n is low
    repeat (3) idle();
    trst_n = 1'b1;
    idle();
    ir_tag = "R3";

    // R2/R4/R5/R6: every code, then a short data scan under it
    for (int c = 0; c < 16; c++) begin
      load_ir(c);
      dr_scan(5, 32'h5A3C_96E1 ^ c);
    end

    // R8: full identification scan with extra bits
    load_ir(14);
    dr_scan(34, 32'hC0DE_1234);

    // R7: bypass delay with a longer pattern
    load_ir(15);
    dr_scan(12, 32'h0000_0B6D);

    // R3: new code shifted but not updated leaves the selection
    load_ir(11);
    shift_ir_code(14);
    idle();
    dr_scan(6, 32'h0000_0033);

    // R1: test-logic-reset and update on the same edge
    load_ir(15);
    shift_ir_code(0);
    ir_tag = "R1";
    step(1, 0, 0, 1, 0, 0, 0);
    idle();
    ir_tag = "R3";

    // R1: test-logic-reset alone
    load_ir(8);
    ir_tag = "R1";
    step(1, 0, 0, 0, 0, 0, 0);
    idle();
    ir_tag = "R3";

    // R1: asynchronous trst between edges
    load_ir(10);
    step(0, 0, 0, 0, 0, 1, 1);
    trst_n = 1'b0;
    #1;
    cmp("R1", int'(ir_q), 14);
    cmp("R1", int'(tdo), 0);
    model_reset();
    #1;
    ir_tag = "R1";
    st_shift_dr = 0;
    @(posedge tck); #2;
    idle();
    trst_n = 1'b1;
    idle();
    ir_tag = "R3";
    dr_scan(4, 32'h0000_0009);

    finish_run();
  end

endmodule